// File: doc/BRIEF.md
# Burst-Ramped Lookup Pulse Shaper

This block shapes one transmit channel of a burst QPSK modulator. One data bit arrives per symbol, and the block emits signed multi-bit samples at eight times the symbol rate. A burst modulator uses two copies: one for the in-phase rail and one for the quadrature rail. Each output sample is read from a precomputed table of root-raised-cosine values with a roll-off of 0.4. The table covers the transmit half of the overall shaping, with a response spanning 8 symbols at 8 samples per symbol. There is no multiply-accumulate datapath. The table is addressed by three things: the recent symbol history, the sample phase within the current symbol, and a 4-bit amplitude level. The table contents are computed when the design is elaborated.

The amplitude level is part of the table address, so the burst power envelope needs no multiplier. A ramp controller raises the level one step at a time at the start of a burst and lowers it the same way at the end. This keeps spectral splatter into neighbouring channels low. At level 0 the output is held at exactly zero, which keeps the carrier silent between bursts. The table is split into two half-history lookups whose results are added in the output register. This keeps the stored depth at two banks of 2048 words.

The block runs on a sample-rate clock qualified by `smp_en`. The caller presents the next data bit on `sym_bit` and may request a burst start or a burst end on any clock.

Top module: `shp_burst_filter`

## Requirements
- R1: While the synchronised reset is active, and on the first enabled cycle after it, the state is as follows: `sample_out` is 0, `gain_level` is 0, `ramp_done` is 0, the sample phase is 0 and all 8 history bits are 0. `rst_n` asserts the reset asynchronously. Its release passes through a two-flop synchroniser.
- R2: The sample phase counts enabled cycles from 0 to 7 and then wraps. On the enabled cycle where the phase is 7, `sym_bit` becomes history bit 0 (the newest symbol) and the oldest bit is dropped. A cycle with `smp_en` low changes nothing: `sample_out`, `gain_level`, the phase and the history all hold.
- R3: Each enabled cycle registers into `sample_out` a table value. The value uses the level L, phase p and history s as they stood before that edge. It is the sum over two halves: history bits 3..0 form one half and bits 7..4 the other. Each half contributes round_half_away(L*A/15), where A is the sum over the half's bits k of +tap[8k+p] when bit k is 1 and -tap[8k+p] when it is 0. Each tap is tap[n] = round_half_away(G*h((n-31.5)/8)), where h is the root-raised-cosine pulse with roll-off 0.4, and G = 500 divided by the largest, over p, of the sum over k of |h((8k+p-31.5)/8)|.
- R4: At level 0 the registered sample is exactly 0 whatever the history holds.
- R5: A `burst_on` request in the idle state starts a rise. The level rises by 1 on every 8th enabled cycle after the request and reaches 15 after 120 enabled cycles. It then holds at 15.
- R6: A `burst_off` request while holding at 15 starts a fall. The level falls by 1 on every 8th enabled cycle down to 0, and the controller then returns to idle.
- R7: `ramp_done` is high for exactly one clock. It rises at the same edge where the level takes its final value of a rise (15) or of a fall (0).
- R8: `burst_on` is ignored in every state except idle, and `burst_off` in every state except the hold at 15. Neither request can reverse or restart a ramp in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_en | input | 1 | Sample clock enable; one output sample per high cycle |
| sym_bit | input | 1 | Next data bit (1 maps to +1, 0 to -1), taken when the phase is 7 |
| burst_on | input | 1 | Request to ramp the amplitude up |
| burst_off | input | 1 | Request to ramp the amplitude down |
| sample_out | output | 10 | Shaped signed sample |
| gain_level | output | 4 | Current amplitude level, 0 to 15 |
| ramp_done | output | 1 | One-clock pulse when a rise or fall completes |

## Verification
The hardest situations to reach from the ports are requests that arrive while a ramp is under way, and enable gaps that straddle a level step. A wrong design there shows only a few hundred cycles later, as a shifted level staircase. The stimulus pulses both requests inside rises and falls, and drops `smp_en` at random throughout each ramp, so that step boundaries land on every alignment. Fixed all-ones, all-zeros and alternating histories exercise the table at its extremes. A long random run mixes data, enable gaps and sparse requests.

// File: rtl/shp_pkg.sv
package shp_pkg;

  localparam int  TAP_MAX  = 64;
  localparam int  TAP_W    = 16;
  localparam int  TAP_BITS = TAP_MAX * TAP_W;
  localparam real PI_R     = 3.14159265358979323846;

  typedef enum logic [1:0] {
    RAMP_IDLE,
    RAMP_RISE,
    RAMP_HIGH,
    RAMP_FALL
  } ramp_state_e;

  // Series sine, argument folded into [-pi, pi]
  function automatic real sin_fn(input real x);
    real y;
    real term;
    real acc;
    y = x;
    for (int i = 0; i < 16; i++) begin
      if (y > PI_R) y = y - 2.0 * PI_R;
      else if (y < -PI_R) y = y + 2.0 * PI_R;
    end
    term = y;
    acc  = y;
    for (int i = 1; i < 14; i++) begin
      term = -term * y * y / real'((2 * i) * (2 * i + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic real cos_fn(input real x);
    return sin_fn(x + PI_R / 2.0);
  endfunction

  // Root-raised-cosine pulse, t in symbol periods
  function automatic real rrc_fn(input real t_in, input real a);
    real t;
    real x;
    real num;
    real den;
    t = t_in;
    if (t < 1.0e-9 && t > -1.0e-9) t = 1.0e-6;
    x   = PI_R * t;
    num = sin_fn(x * (1.0 - a)) + 4.0 * a * t * cos_fn(x * (1.0 + a));
    den = x * (1.0 - (4.0 * a * t) * (4.0 * a * t));
    if (den < 1.0e-12 && den > -1.0e-12) den = 1.0e-12;
    return num / den;
  endfunction

  function automatic int round_fn(input real r);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  function automatic real tap_real(input int n, input int sps, input int span, input int alpha_pct);
    real t;
    t = (real'(n) - real'(sps * span - 1) / 2.0) / real'(sps);
    return rrc_fn(t, real'(alpha_pct) / 100.0);
  endfunction

  // Quantised taps, normalised so the worst phase sum reaches peak
  function automatic logic [TAP_BITS-1:0] build_taps(input int sps, input int span,
                                                     input int alpha_pct, input int peak);
    logic [TAP_BITS-1:0] v;
    real mx;
    real s;
    real h;
    real g;
    v  = '0;
    mx = 0.0;
    for (int p = 0; p < sps; p++) begin
      s = 0.0;
      for (int k = 0; k < span; k++) begin
        h = tap_real(k * sps + p, sps, span, alpha_pct);
        s = s + ((h < 0.0) ? -h : h);
      end
      if (s > mx) mx = s;
    end
    g = real'(peak) / mx;
    for (int n = 0; n < sps * span; n++) begin
      v[n*TAP_W +: TAP_W] = TAP_W'(round_fn(g * tap_real(n, sps, span, alpha_pct)));
    end
    return v;
  endfunction

  // One word of a partial table: address = {level, phase, history part}
  function automatic int part_entry(input logic [TAP_BITS-1:0] taps, input int part,
                                    input int addr, input int sps, input int ph_w,
                                    input int part_syms, input int scale_w);
    int lvl;
    int ph;
    int acc;
    int n;
    int tv;
    int prod;
    int full;
    lvl = addr >> (ph_w + part_syms);
    ph  = (addr >> part_syms) % sps;
    acc = 0;
    for (int j = 0; j < part_syms; j++) begin
      n  = (part * part_syms + j) * sps + ph;
      tv = int'($signed(taps[n*TAP_W +: TAP_W]));
      if (((addr >> j) & 1) != 0) acc = acc + tv;
      else acc = acc - tv;
    end
    prod = acc * lvl;
    full = (1 << scale_w) - 1;
    if (prod >= 0) return (2 * prod + full) / (2 * full);
    return -((-2 * prod + full) / (2 * full));
  endfunction

endpackage

// File: rtl/shp_sym_track.sv
module shp_sym_track #(
  parameter int SPS  = 8,
  parameter int SPAN = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic                    sym_bit,
  output logic [$clog2(SPS)-1:0]  phase,
  output logic [SPAN-1:0]         history
);

  localparam int PH_W = $clog2(SPS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SPS - 1);

  logic [PH_W-1:0] phase_q, phase_d;
  logic [SPAN-1:0] hist_q, hist_d;

  always_comb begin
    phase_d = phase_q;
    hist_d  = hist_q;
    if (smp_en) begin
      if (phase_q == PH_LAST) begin
        phase_d = '0;
        hist_d  = {hist_q[SPAN-2:0], sym_bit};
      end else begin
        phase_d = phase_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      hist_q  <= '0;
    end else begin
      phase_q <= phase_d;
      hist_q  <= hist_d;
    end
  end

  assign phase   = phase_q;
  assign history = hist_q;

endmodule

// File: rtl/shp_ramp_ctrl.sv
module shp_ramp_ctrl
  import shp_pkg::*;
#(
  parameter int SCALE_W = 4,
  parameter int SPS     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_en,
  input  logic               burst_on,
  input  logic               burst_off,
  output logic [SCALE_W-1:0] level,
  output logic               done
);

  localparam int STEP_W = $clog2(SPS);
  localparam logic [STEP_W-1:0]  STEP_LAST = STEP_W'(SPS - 1);
  localparam logic [SCALE_W-1:0] LVL_TOP   = {SCALE_W{1'b1}};
  localparam logic [SCALE_W-1:0] LVL_PRE   = LVL_TOP - SCALE_W'(1);
  localparam logic [SCALE_W-1:0] LVL_ONE   = SCALE_W'(1);

  ramp_state_e        state_q, state_d;
  logic [STEP_W-1:0]  step_q, step_d;
  logic [SCALE_W-1:0] level_q, level_d;
  logic               done_q, done_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    level_d = level_q;
    done_d  = 1'b0;
    unique case (state_q)
      RAMP_IDLE: begin
        if (burst_on) begin
          state_d = RAMP_RISE;
          step_d  = '0;
        end
      end
      RAMP_RISE: begin
        if (smp_en) begin
          if (step_q == STEP_LAST) begin
            step_d  = '0;
            level_d = level_q + SCALE_W'(1);
            if (level_q == LVL_PRE) begin
              state_d = RAMP_HIGH;
              done_d  = 1'b1;
            end
          end else begin
            step_d = step_q + STEP_W'(1);
          end
        end
      end
      RAMP_HIGH: begin
        if (burst_off) begin
          state_d = RAMP_FALL;
          step_d  = '0;
        end
      end
      RAMP_FALL: begin
        if (smp_en) begin
          if (step_q == STEP_LAST) begin
            step_d  = '0;
            level_d = level_q - SCALE_W'(1);
            if (level_q == LVL_ONE) begin
              state_d = RAMP_IDLE;
              done_d  = 1'b1;
            end
          end else begin
            step_d = step_q + STEP_W'(1);
          end
        end
      end
      default: state_d = RAMP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RAMP_IDLE;
      step_q  <= '0;
      level_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      level_q <= level_d;
      done_q  <= done_d;
    end
  end

  assign level = level_q;
  assign done  = done_q;

endmodule

// File: rtl/shp_part_rom.sv
module shp_part_rom
  import shp_pkg::*;
#(
  parameter int                  PART      = 0,
  parameter int                  SPS       = 8,
  parameter int                  PART_SYMS = 4,
  parameter int                  SCALE_W   = 4,
  parameter int                  OUT_W     = 10,
  parameter logic [TAP_BITS-1:0] TAPS      = '0
) (
  input  logic [SCALE_W+$clog2(SPS)+PART_SYMS-1:0] addr,
  output logic signed [OUT_W-1:0]                  data
);

  localparam int PH_W  = $clog2(SPS);
  localparam int AW    = SCALE_W + PH_W + PART_SYMS;
  localparam int DEPTH = 1 << AW;

  logic signed [OUT_W-1:0] table_w [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    localparam int VAL = part_entry(TAPS, PART, a, SPS, PH_W, PART_SYMS, SCALE_W);
    assign table_w[a] = OUT_W'(VAL);
  end

  assign data = table_w[addr];

endmodule

// File: rtl/shp_burst_filter.sv
module shp_burst_filter
  import shp_pkg::*;
#(
  parameter int SPS       = 8,
  parameter int SPAN      = 8,
  parameter int ALPHA_PCT = 40,
  parameter int SCALE_W   = 4,
  parameter int OUT_W     = 10,
  parameter int PEAK      = 500,
  parameter int PARTS     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic                    sym_bit,
  input  logic                    burst_on,
  input  logic                    burst_off,
  output logic signed [OUT_W-1:0] sample_out,
  output logic [SCALE_W-1:0]      gain_level,
  output logic                    ramp_done
);

  localparam int PH_W      = $clog2(SPS);
  localparam int PART_SYMS = SPAN / PARTS;
  localparam int PART_AW   = SCALE_W + PH_W + PART_SYMS;
  localparam logic [TAP_BITS-1:0] TAPS = build_taps(SPS, SPAN, ALPHA_PCT, PEAK);

  logic [1:0]              rst_sync_q;
  logic                    core_rst_n;
  logic [PH_W-1:0]         phase;
  logic [SPAN-1:0]         history;
  logic [SCALE_W-1:0]      level;
  logic signed [OUT_W-1:0] part_val [PARTS];
  logic signed [OUT_W-1:0] sum_w;
  logic signed [OUT_W-1:0] out_q, out_d;

  // Reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  shp_sym_track #(.SPS(SPS), .SPAN(SPAN)) u_track (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .smp_en  (smp_en),
    .sym_bit (sym_bit),
    .phase   (phase),
    .history (history)
  );

  shp_ramp_ctrl #(.SCALE_W(SCALE_W), .SPS(SPS)) u_ramp (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .smp_en    (smp_en),
    .burst_on  (burst_on),
    .burst_off (burst_off),
    .level     (level),
    .done      (ramp_done)
  );

  for (genvar p = 0; p < PARTS; p++) begin : g_part
    logic [PART_AW-1:0] addr;
    assign addr = {level, phase, history[p*PART_SYMS +: PART_SYMS]};
    shp_part_rom #(
      .PART      (p),
      .SPS       (SPS),
      .PART_SYMS (PART_SYMS),
      .SCALE_W   (SCALE_W),
      .OUT_W     (OUT_W),
      .TAPS      (TAPS)
    ) u_rom (
      .addr (addr),
      .data (part_val[p])
    );
  end

  always_comb begin
    sum_w = '0;
    for (int p = 0; p < PARTS; p++) begin
      sum_w = sum_w + part_val[p];
    end
  end

  always_comb out_d = smp_en ? sum_w : out_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) out_q <= '0;
    else             out_q <= out_d;
  end

  assign sample_out = out_q;
  assign gain_level = level;

endmodule

// File: rtl/shp_burst_filter_chk.sv
module shp_burst_filter_chk #(
  parameter int OUT_W   = 10,
  parameter int SCALE_W = 4,
  parameter int PEAK    = 500
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_en,
  input logic signed [OUT_W-1:0] sample_out,
  input logic [SCALE_W-1:0]      gain_level,
  input logic                    ramp_done
);

  assert_hold_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ($stable(sample_out) && $stable(gain_level)));

  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sample_out) <= PEAK + 8) && (int'(sample_out) >= -(PEAK + 8)));

  assert_zero_at_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && gain_level == '0) |=> (sample_out == '0));

  assert_level_on_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_level) |-> $past(smp_en));

  assert_rise_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_level > $past(gain_level)) |-> (gain_level == $past(gain_level) + SCALE_W'(1)));

  assert_fall_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_level < $past(gain_level)) |-> (gain_level == $past(gain_level) - SCALE_W'(1)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |=> !ramp_done);

  assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |-> (gain_level == '0 || gain_level == '1));

endmodule

bind shp_burst_filter shp_burst_filter_chk #(
  .OUT_W   (OUT_W),
  .SCALE_W (SCALE_W),
  .PEAK    (PEAK)
) u_chk (
  .clk        (clk),
  .rst_n      (core_rst_n),
  .smp_en     (smp_en),
  .sample_out (sample_out),
  .gain_level (gain_level),
  .ramp_done  (ramp_done)
);

// File: tb/shp_burst_filter_bench.sv
module shp_burst_filter_bench;

  localparam real PI_B = 3.14159265358979323846;

  logic              clk;
  logic              rst_n;
  logic              smp_en;
  logic              sym_bit;
  logic              burst_on;
  logic              burst_off;
  logic signed [9:0] sample_out;
  logic [3:0]        gain_level;
  logic              ramp_done;

  int n_checks;
  int n_err;
  int tapv [64];
  string cur_tag;

  // Reference model state
  int         m_phase;
  logic [7:0] m_sym;
  int         m_level;
  int         m_state;   // 0 idle, 1 rise, 2 hold, 3 fall
  int         m_step;
  int         m_out;
  int         m_done;

  shp_burst_filter u_shp_burst_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (smp_en),
    .sym_bit    (sym_bit),
    .burst_on   (burst_on),
    .burst_off  (burst_off),
    .sample_out (sample_out),
    .gain_level (gain_level),
    .ramp_done  (ramp_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic real pulse_b(input int n);
    real t;
    real x;
    real a;
    real num;
    real den;
    a   = 0.4;
    t   = (real'(n) - 31.5) / 8.0;
    x   = PI_B * t;
    num = $sin(x * (1.0 - a)) + 4.0 * a * t * $cos(x * (1.0 + a));
    den = x * (1.0 - (4.0 * a * t) * (4.0 * a * t));
    return num / den;
  endfunction

  function automatic int rnd_b(input real r);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  function automatic int div15(input int x);
    if (x >= 0) return (2 * x + 15) / 30;
    return -((-2 * x + 15) / 30);
  endfunction

  task automatic make_taps();
    real mx;
    real s;
    real h;
    real g;
    mx = 0.0;
    for (int p = 0; p < 8; p++) begin
      s = 0.0;
      for (int k = 0; k < 8; k++) begin
        h = pulse_b(k * 8 + p);
        s = s + ((h < 0.0) ? -h : h);
      end
      if (s > mx) mx = s;
    end
    g = 500.0 / mx;
    for (int n = 0; n < 64; n++) tapv[n] = rnd_b(g * pulse_b(n));
  endtask

  // R3: two half-history sums, each scaled by level/15 and rounded
  function automatic int exp_sample(input int lvl, input int ph, input logic [7:0] sy);
    int total;
    int acc;
    int k;
    total = 0;
    for (int hp = 0; hp < 2; hp++) begin
      acc = 0;
      for (int j = 0; j < 4; j++) begin
        k = hp * 4 + j;
        if (sy[k]) acc = acc + tapv[k * 8 + ph];
        else       acc = acc - tapv[k * 8 + ph];
      end
      total = total + div15(acc * lvl);
    end
    return total;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(input logic en, input logic b, input logic on, input logic off);
    int nout;
    int ndone;
    nout  = en ? exp_sample(m_level, m_phase, m_sym) : m_out;
    ndone = 0;
    case (m_state)
      0: if (on) begin m_state = 1; m_step = 0; end
      1: if (en) begin
           if (m_step == 7) begin
             m_step  = 0;
             m_level = m_level + 1;
             if (m_level == 15) begin m_state = 2; ndone = 1; end
           end else m_step = m_step + 1;
         end
      2: if (off) begin m_state = 3; m_step = 0; end
      default: if (en) begin
           if (m_step == 7) begin
             m_step  = 0;
             m_level = m_level - 1;
             if (m_level == 0) begin m_state = 0; ndone = 1; end
           end else m_step = m_step + 1;
         end
    endcase
    if (en) begin
      if (m_phase == 7) begin
        m_phase = 0;
        m_sym   = {m_sym[6:0], b};
      end else m_phase = m_phase + 1;
    end
    m_out  = nout;
    m_done = ndone;
  endtask

  task automatic compare();
    chk(int'(sample_out) == m_out, cur_tag, "sample_out", int'(sample_out), m_out);
    chk(int'(gain_level) == m_level, cur_tag, "gain_level", int'(gain_level), m_level);
    chk(int'(ramp_done) == m_done, "R7", "ramp_done", int'(ramp_done), m_done);
  endtask

  // Called at a falling edge; drives, waits one rising edge, checks at the next falling edge
  task automatic cyc(input logic en, input logic b, input logic on, input logic off);
    smp_en    = en;
    sym_bit   = b;
    burst_on  = on;
    burst_off = off;
    @(posedge clk);
    model_step(en, b, on, off);
    @(negedge clk);
    compare();
  endtask

  function automatic logic rbit();
    return logic'($urandom & 1);
  endfunction

  function automatic logic ren(input int pct);
    return logic'(($urandom % 100) < pct);
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all requirements) actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed_w;
    n_checks  = 0;
    n_err     = 0;
    seed_w    = $urandom(32'd1997);
    make_taps();
    rst_n     = 1'b0;
    smp_en    = 1'b0;
    sym_bit   = 1'b0;
    burst_on  = 1'b0;
    burst_off = 1'b0;
    m_phase = 0; m_sym = '0; m_level = 0; m_state = 0; m_step = 0; m_out = 0; m_done = 0;

    // R1: reset state
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    repeat (3) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);

    // R4: level 0 gives silence for any data
    cur_tag = "R4";
    for (int i = 0; i < 150; i++) cyc(ren(80), rbit(), 1'b0, 1'b0);

    // R5: clean rise with enable gaps
    cur_tag = "R5";
    cyc(ren(50), rbit(), 1'b1, 1'b0);
    for (int i = 0; i < 400 && m_state != 2; i++) cyc(ren(75), rbit(), 1'b0, 1'b0);
    chk(int'(gain_level) == 15, "R5", "level after rise", int'(gain_level), 15);

    // R3: fixed histories at full level, then random data
    cur_tag = "R3";
    for (int i = 0; i < 80; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 80; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 128; i++) cyc(1'b1, logic'((i >> 3) & 1), 1'b0, 1'b0);
    for (int i = 0; i < 400; i++) cyc(ren(70), rbit(), 1'b0, 1'b0);

    // R2: enable held low, then sparse enables
    cur_tag = "R2";
    for (int i = 0; i < 30; i++) cyc(1'b0, rbit(), 1'b0, 1'b0);
    for (int i = 0; i < 90; i++) cyc(logic'(i % 3 == 0), rbit(), 1'b0, 1'b0);

    // R8: requests in the wrong state are ignored
    cur_tag = "R8";
    cyc(1'b1, rbit(), 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) cyc(ren(80), rbit(), 1'b0, 1'b0);
    chk(int'(gain_level) == 15, "R8", "level after stray burst_on", int'(gain_level), 15);
    cyc(1'b1, rbit(), 1'b0, 1'b1);
    for (int i = 0; i < 400 && m_state != 0; i++)
      cyc(ren(80), rbit(), logic'(i % 11 == 5), logic'(i % 13 == 3));
    chk(int'(gain_level) == 0, "R8", "level after fall with stray requests", int'(gain_level), 0);
    cyc(1'b1, rbit(), 1'b1, 1'b0);
    for (int i = 0; i < 400 && m_state != 2; i++)
      cyc(ren(80), rbit(), 1'b0, logic'(i % 9 == 4));
    chk(int'(gain_level) == 15, "R8", "level after rise with stray burst_off", int'(gain_level), 15);

    // R6: clean fall
    cur_tag = "R6";
    cyc(1'b0, rbit(), 1'b0, 1'b1);
    for (int i = 0; i < 400 && m_state != 0; i++) cyc(ren(70), rbit(), 1'b0, 1'b0);
    chk(int'(gain_level) == 0, "R6", "level after fall", int'(gain_level), 0);
    for (int i = 0; i < 20; i++) cyc(1'b1, rbit(), 1'b0, 1'b0);

    // R3: long random mix of data, gaps and sparse requests
    cur_tag = "R3";
    for (int i = 0; i < 3000; i++)
      cyc(ren(80), rbit(), logic'(($urandom % 150) == 0), logic'(($urandom % 150) == 0));

    finish_run();
  end

endmodule